// File: doc/BRIEF.md
# Bias search controller

This block sets an amplifier's bias current with a digital control loop. It looks for the lowest current-DAC code at which a noise figure meets a programmable limit. The noise figure is not measured. It is predicted on chip from three quantized sensor readings and from the bias code itself. After a start pulse the controller sets the code to its minimum. For each code it then takes one reading from each of three sensors:

- a detector voltage: 5 bits, 0 V to 0.1 V;
- a bias-node DC voltage: 4 bits, 0.2 V to 0.4 V;
- a temperature: 4 bits, -20 °C to 80 °C.

In each case code 0 is the low end of the range. Each sensor converter is reached through its own request/acknowledge port.

With the four codes the block evaluates a fixed sparse polynomial. It has eleven programmable signed coefficients and uses one shared multiplier and accumulator, one term per cycle. It adds a guard band to the result and compares the sum with the limit. If the limit is missed, the code goes up by one and the loop repeats. The search ends on the first code that meets the limit, or at the maximum code, in which case it reports failure. The coefficients, guard band and limit come from offline fitting and are held stable by the surrounding logic during a search.

Top module: `bias_search_ctrl`

## Requirements
- R1: After synchronous reset the block is idle with `bias_code` at the minimum code, `done` low, `pass` low and no sensor request active.
- R2: A `start` pulse while idle sets `bias_code` to the minimum code and begins a search; a `start` that arrives while a search runs is ignored and neither restarts the search nor changes its result.
- R3: For each code tried, the block requests the detector, then the bias node, then the temperature. At most one request is active at a time. Each request is held until its acknowledge, and the sensor code is captured in the cycle the acknowledge is high.
- R4: With detector code d, node code n, temperature code t, bias code c and coefficient k taken from `coef` bits [16k+15:16k], the prediction is the exact signed sum c0 + c1·d + c2·d² + c3·d³ + c4·c + c5·c² + c6·t + c7·t² + c8·t³ + c9·n³ + c10·d·t, with no wrap-around.
- R5: If the prediction plus `guard` is at or below `limit` (both signed), the search stops at the current code with `pass` high.
- R6: Otherwise, and if the code is below maximum, the code rises by exactly one and sampling and evaluation repeat; during a search `bias_code` changes only by that step.
- R7: If the maximum code misses the limit, the search ends with `bias_code` at the maximum and `pass` low.
- R8: `done` is a one-cycle pulse that marks the end of a search. `bias_code` and `pass` then hold until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a search when idle |
| det_req | output | 1 | Detector conversion request |
| det_ack | input | 1 | Detector conversion done |
| det_code | input | DET_W | Detector voltage code |
| node_req | output | 1 | Bias-node conversion request |
| node_ack | input | 1 | Bias-node conversion done |
| node_code | input | NODE_W | Bias-node voltage code |
| temp_req | output | 1 | Temperature conversion request |
| temp_ack | input | 1 | Temperature conversion done |
| temp_code | input | TEMP_W | Temperature code |
| coef | input | 11·COEF_W | Signed coefficients, term k in slice k |
| limit | input | PRED_W | Signed noise-figure limit |
| guard | input | PRED_W | Signed guard band |
| bias_code | output | CODE_W | Current-DAC code |
| done | output | 1 | End-of-search pulse |
| pass | output | 1 | Limit met at the final code |

## Verification
The following properties are checked on every cycle:
- request exclusivity and request hold until acknowledge;
- no request while idle;
- the bias code moves only by single upward steps or back to minimum;
- the one-cycle `done` pulse;
- a failure flag only at the maximum code;
- stable outputs while idle.

Only the bench's scenarios show the rest:
- the exact polynomial value and the at-or-below comparison boundary;
- that the chosen code is the first passing one;
- the number and order of sensor readings per search;
- that a mid-search start or reset has the required effect.

// File: rtl/bias_search_pkg.sv
package bias_search_pkg;
   localparam int NUM_TERMS = 11;

   // term order: position k selects coefficient slice k
   localparam int T_CONST = 0;
   localparam int T_D1    = 1;
   localparam int T_D2    = 2;
   localparam int T_D3    = 3;
   localparam int T_C1    = 4;
   localparam int T_C2    = 5;
   localparam int T_T1    = 6;
   localparam int T_T2    = 7;
   localparam int T_T3    = 8;
   localparam int T_N3    = 9;
   localparam int T_DT    = 10;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DET,
      ST_NODE,
      ST_TEMP,
      ST_EVAL,
      ST_DECIDE
   } bsc_state_e;
endpackage

// File: rtl/bsc_monomial.sv
module bsc_monomial
   import bias_search_pkg::*;
#(
   parameter int DET_W  = 5,
   parameter int NODE_W = 4,
   parameter int TEMP_W = 4,
   parameter int CODE_W = 4,
   parameter int MONO_W = 15,
   parameter int TIDX_W = 4
) (
   input  logic [TIDX_W-1:0] term,
   input  logic [DET_W-1:0]  det,
   input  logic [NODE_W-1:0] node,
   input  logic [TEMP_W-1:0] temp,
   input  logic [CODE_W-1:0] code,
   output logic [MONO_W-1:0] mono
);
   logic [MONO_W-1:0] d, n, t, c;

   assign d = MONO_W'(det);
   assign n = MONO_W'(node);
   assign t = MONO_W'(temp);
   assign c = MONO_W'(code);

   always_comb begin
      case (term)
         TIDX_W'(T_CONST): mono = MONO_W'(1);
         TIDX_W'(T_D1):    mono = d;
         TIDX_W'(T_D2):    mono = d * d;
         TIDX_W'(T_D3):    mono = d * d * d;
         TIDX_W'(T_C1):    mono = c;
         TIDX_W'(T_C2):    mono = c * c;
         TIDX_W'(T_T1):    mono = t;
         TIDX_W'(T_T2):    mono = t * t;
         TIDX_W'(T_T3):    mono = t * t * t;
         TIDX_W'(T_N3):    mono = n * n * n;
         TIDX_W'(T_DT):    mono = d * t;
         default:          mono = '0;
      endcase
   end
endmodule

// File: rtl/bsc_mac.sv
module bsc_mac #(
   parameter int COEF_W = 16,
   parameter int MONO_W = 15,
   parameter int PRED_W = 40
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     clr,
   input  logic                     en,
   input  logic signed [COEF_W-1:0] coef,
   input  logic [MONO_W-1:0]        mono,
   output logic signed [PRED_W-1:0] acc
);
   localparam int PROD_W = COEF_W + MONO_W + 1;

   logic signed [PROD_W-1:0] prod;

   assign prod = PROD_W'(coef) * PROD_W'($signed({1'b0, mono}));

   always_ff @(posedge clk) begin
      if (rst || clr)
         acc <= '0;
      else if (en)
         acc <= acc + PRED_W'(prod);
   end
endmodule

// File: rtl/bias_search_ctrl.sv
module bias_search_ctrl
   import bias_search_pkg::*;
#(
   parameter int DET_W    = 5,
   parameter int NODE_W   = 4,
   parameter int TEMP_W   = 4,
   parameter int CODE_W   = 4,
   parameter int CODE_MIN = 0,
   parameter int CODE_MAX = 15,
   parameter int COEF_W   = 16,
   parameter int PRED_W   = 40
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic                          start,
   output logic                          det_req,
   input  logic                          det_ack,
   input  logic [DET_W-1:0]              det_code,
   output logic                          node_req,
   input  logic                          node_ack,
   input  logic [NODE_W-1:0]             node_code,
   output logic                          temp_req,
   input  logic                          temp_ack,
   input  logic [TEMP_W-1:0]             temp_code,
   input  logic [NUM_TERMS*COEF_W-1:0]   coef,
   input  logic signed [PRED_W-1:0]      limit,
   input  logic signed [PRED_W-1:0]      guard,
   output logic [CODE_W-1:0]             bias_code,
   output logic                          done,
   output logic                          pass
);
   localparam int MAX_A  = (3*DET_W > 3*NODE_W) ? 3*DET_W : 3*NODE_W;
   localparam int MAX_B  = (3*TEMP_W > 2*CODE_W) ? 3*TEMP_W : 2*CODE_W;
   localparam int MAX_AB = (MAX_A > MAX_B) ? MAX_A : MAX_B;
   localparam int MONO_W = (MAX_AB > DET_W + TEMP_W) ? MAX_AB : DET_W + TEMP_W;
   localparam int PROD_W = COEF_W + MONO_W + 1;
   localparam int TIDX_W = $clog2(NUM_TERMS);
   localparam int EXT_W  = PRED_W + 1;

   if (CODE_MIN >= CODE_MAX || CODE_MAX >= (1 << CODE_W)) begin : g_bad_code
      $error("bias_search_ctrl: code range does not fit CODE_W");
   end
   if (PRED_W < PROD_W + TIDX_W + 1) begin : g_bad_pred
      $error("bias_search_ctrl: PRED_W too narrow for the term sum");
   end
   if (COEF_W < 2 || DET_W < 1 || NODE_W < 1 || TEMP_W < 1) begin : g_bad_width
      $error("bias_search_ctrl: operand widths too small");
   end

   bsc_state_e                st;
   logic [TIDX_W-1:0]         tidx;
   logic [DET_W-1:0]          det_q;
   logic [NODE_W-1:0]         node_q;
   logic [TEMP_W-1:0]         temp_q;
   logic [MONO_W-1:0]         mono;
   logic signed [COEF_W-1:0]  coef_arr [NUM_TERMS];
   logic signed [COEF_W-1:0]  coef_sel;
   logic signed [PRED_W-1:0]  acc;
   logic signed [EXT_W-1:0]   guarded;
   logic                      meets;
   logic                      busy;

   for (genvar k = 0; k < NUM_TERMS; k++) begin : g_coef
      assign coef_arr[k] = coef[k*COEF_W +: COEF_W];
   end

   assign coef_sel = coef_arr[tidx];
   assign det_req  = (st == ST_DET);
   assign node_req = (st == ST_NODE);
   assign temp_req = (st == ST_TEMP);
   assign busy     = (st != ST_IDLE);
   assign guarded  = EXT_W'(acc) + EXT_W'(guard);
   assign meets    = (guarded <= EXT_W'(limit));

   bsc_monomial #(
      .DET_W(DET_W), .NODE_W(NODE_W), .TEMP_W(TEMP_W),
      .CODE_W(CODE_W), .MONO_W(MONO_W), .TIDX_W(TIDX_W)
   ) i_mono (
      .term(tidx), .det(det_q), .node(node_q), .temp(temp_q),
      .code(bias_code), .mono(mono)
   );

   bsc_mac #(
      .COEF_W(COEF_W), .MONO_W(MONO_W), .PRED_W(PRED_W)
   ) i_mac (
      .clk(clk), .rst(rst), .clr(st == ST_TEMP), .en(st == ST_EVAL),
      .coef(coef_sel), .mono(mono), .acc(acc)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         st        <= ST_IDLE;
         tidx      <= '0;
         det_q     <= '0;
         node_q    <= '0;
         temp_q    <= '0;
         bias_code <= CODE_W'(CODE_MIN);
         done      <= 1'b0;
         pass      <= 1'b0;
      end else begin
         done <= 1'b0;
         case (st)
            ST_IDLE: if (start) begin
               bias_code <= CODE_W'(CODE_MIN);
               pass      <= 1'b0;
               st        <= ST_DET;
            end
            ST_DET: if (det_ack) begin
               det_q <= det_code;
               st    <= ST_NODE;
            end
            ST_NODE: if (node_ack) begin
               node_q <= node_code;
               st     <= ST_TEMP;
            end
            ST_TEMP: if (temp_ack) begin
               temp_q <= temp_code;
               tidx   <= '0;
               st     <= ST_EVAL;
            end
            ST_EVAL: begin
               tidx <= tidx + 1'b1;
               if (tidx == TIDX_W'(NUM_TERMS - 1))
                  st <= ST_DECIDE;
            end
            ST_DECIDE: begin
               if (meets) begin
                  done <= 1'b1;
                  pass <= 1'b1;
                  st   <= ST_IDLE;
               end else if (bias_code == CODE_W'(CODE_MAX)) begin
                  done <= 1'b1;
                  st   <= ST_IDLE;
               end else begin
                  bias_code <= bias_code + 1'b1;
                  st        <= ST_DET;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/bsc_checker.sv
module bsc_checker #(
   parameter int CODE_W   = 4,
   parameter int CODE_MIN = 0,
   parameter int CODE_MAX = 15
) (
   input logic              clk,
   input logic              rst,
   input logic              start,
   input logic              busy,
   input logic              det_req,
   input logic              det_ack,
   input logic              node_req,
   input logic              node_ack,
   input logic              temp_req,
   input logic              temp_ack,
   input logic [CODE_W-1:0] bias_code,
   input logic              done,
   input logic              pass
);
   p_one_req_r3: assert property (@(posedge clk) disable iff (rst)
      $onehot0({det_req, node_req, temp_req}));

   p_det_hold_r3: assert property (@(posedge clk) disable iff (rst)
      det_req && !det_ack |=> det_req);

   p_node_hold_r3: assert property (@(posedge clk) disable iff (rst)
      node_req && !node_ack |=> node_req);

   p_temp_hold_r3: assert property (@(posedge clk) disable iff (rst)
      temp_req && !temp_ack |=> temp_req);

   p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
      !busy |-> !(det_req || node_req || temp_req));

   p_code_step_r6: assert property (@(posedge clk) disable iff (rst)
      !$stable(bias_code) |->
         (bias_code == CODE_W'($past(bias_code) + 1'b1)) ||
         (bias_code == CODE_W'(CODE_MIN)));

   p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);

   p_done_idle_r8: assert property (@(posedge clk) disable iff (rst)
      done |-> !busy);

   p_fail_at_max_r7: assert property (@(posedge clk) disable iff (rst)
      done && !pass |-> bias_code == CODE_W'(CODE_MAX));

   p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
      !busy && !start |=> $stable(bias_code) && $stable(pass));
endmodule

bind bias_search_ctrl bsc_checker #(
   .CODE_W(CODE_W), .CODE_MIN(CODE_MIN), .CODE_MAX(CODE_MAX)
) i_bsc_checker (
   .clk(clk), .rst(rst), .start(start), .busy(busy),
   .det_req(det_req), .det_ack(det_ack),
   .node_req(node_req), .node_ack(node_ack),
   .temp_req(temp_req), .temp_ack(temp_ack),
   .bias_code(bias_code), .done(done), .pass(pass)
);

// File: tb/test_bias_search_ctrl.sv
`timescale 1ns/1ps
module test_bias_search_ctrl;
   localparam int DET_W = 5, NODE_W = 4, TEMP_W = 4, CODE_W = 4;
   localparam int COEF_W = 16, PRED_W = 40, NT = 11;

   logic clk = 1'b0, rst = 1'b1, start = 1'b0;
   logic det_req, node_req, temp_req;
   logic det_ack = 1'b0, node_ack = 1'b0, temp_ack = 1'b0;
   logic [DET_W-1:0]  det_code = '0;
   logic [NODE_W-1:0] node_code = '0;
   logic [TEMP_W-1:0] temp_code = '0;
   logic [NT*COEF_W-1:0] coef = '0;
   logic signed [PRED_W-1:0] limit = '0, guard = '0;
   logic [CODE_W-1:0] bias_code;
   logic done, pass;

   int nchk = 0, nerr = 0;
   int acks = 0, ord_err = 0, last_id = 2, cur_id = -1;
   int dmul, doff, nmul, noff, tmul, toff;
   longint cf [NT];
   longint lim, grd;

   always #2.5 clk = ~clk;

   bias_search_ctrl i_bias_search_ctrl (
      .clk(clk), .rst(rst), .start(start),
      .det_req(det_req), .det_ack(det_ack), .det_code(det_code),
      .node_req(node_req), .node_ack(node_ack), .node_code(node_code),
      .temp_req(temp_req), .temp_ack(temp_ack), .temp_code(temp_code),
      .coef(coef), .limit(limit), .guard(guard),
      .bias_code(bias_code), .done(done), .pass(pass)
   );

   function automatic int det_f(int c);  return (c*dmul + doff) % 32; endfunction
   function automatic int node_f(int c); return (c*nmul + noff) % 16; endfunction
   function automatic int temp_f(int c); return (toff + (c*tmul)/4) % 16; endfunction
   function automatic int lat_f(int id); return (int'(bias_code) + id) % 3; endfunction

   function automatic longint mono_f(int k, longint d, longint n, longint t, longint c);
      case (k)
         0: return 1;         1: return d;       2: return d*d;
         3: return d*d*d;     4: return c;       5: return c*c;
         6: return t;         7: return t*t;     8: return t*t*t;
         9: return n*n*n;     default: return d*t;
      endcase
   endfunction

   function automatic longint pred_f(int c);
      longint s = 0;
      for (int k = 0; k < NT; k++)
         s += cf[k] * mono_f(k, det_f(c), node_f(c), temp_f(c), c);
      return s;
   endfunction

   task automatic check(string tag, longint act, longint exp);
      nchk++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // sensor responders
   initial forever begin
      @(negedge clk);
      if (det_req) begin
         repeat (lat_f(0)) @(negedge clk);
         det_code = DET_W'(det_f(int'(bias_code))); det_ack = 1'b1; acks++;
         @(negedge clk); det_ack = 1'b0;
      end
   end
   initial forever begin
      @(negedge clk);
      if (node_req) begin
         repeat (lat_f(1)) @(negedge clk);
         node_code = NODE_W'(node_f(int'(bias_code))); node_ack = 1'b1; acks++;
         @(negedge clk); node_ack = 1'b0;
      end
   end
   initial forever begin
      @(negedge clk);
      if (temp_req) begin
         repeat (lat_f(2)) @(negedge clk);
         temp_code = TEMP_W'(temp_f(int'(bias_code))); temp_ack = 1'b1; acks++;
         @(negedge clk); temp_ack = 1'b0;
      end
   end
   // request order monitor
   initial forever begin
      int id;
      @(negedge clk);
      id = det_req ? 0 : node_req ? 1 : temp_req ? 2 : -1;
      if (id >= 0 && id != cur_id) begin
         if (id != (last_id + 1) % 3) ord_err++;
         last_id = id;
      end
      cur_id = id;
   end

   task automatic load();
      for (int k = 0; k < NT; k++) coef[k*COEF_W +: COEF_W] = cf[k][COEF_W-1:0];
      limit = lim[PRED_W-1:0];
      guard = grd[PRED_W-1:0];
   endtask

   task automatic search(string tag, bit mid_start);
      int ec = 15, ep = 0, cyc = 0;
      logic [CODE_W-1:0] hc; logic hp;
      for (int c = 0; c < 16; c++)
         if (pred_f(c) + grd <= lim) begin ec = c; ep = 1; break; end
      load();
      @(negedge clk);
      acks = 0; ord_err = 0; last_id = 2;
      start = 1'b1;
      @(negedge clk); start = 1'b0;
      while (!done && cyc < 5000) begin
         @(negedge clk); cyc++;
         start = (mid_start && cyc == 40);
      end
      start = 1'b0;
      check({tag, " R5/R6/R7 code"}, longint'(bias_code), ec);
      check({tag, " R5/R7 pass"}, longint'(pass), ep);
      check({tag, " R3 acks"}, acks, 3*(ec+1));
      check({tag, " R3 order"}, ord_err, 0);
      hc = bias_code; hp = pass;
      @(negedge clk);
      check({tag, " R8 pulse"}, longint'(done), 0);
      repeat (4) @(negedge clk);
      check({tag, " R8 hold"}, longint'({hc, hp}), longint'({bias_code, pass}));
   endtask

   initial begin
      #1_000_000;
      nerr++; nchk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      check("R1 reset code", longint'(bias_code), 0);
      check("R1 reset flags", longint'({done, pass, det_req, node_req, temp_req}), 0);

      // R5 boundary sweep on a linear prediction 1000 - 60c, guard 20
      dmul = 1; doff = 2; nmul = 1; noff = 3; tmul = 1; toff = 4;
      for (int k = 0; k < NT; k++) cf[k] = 0;
      cf[0] = 1000; cf[4] = -60; grd = 20;
      for (int j = 0; j <= 16; j++) begin
         lim = 1020 - 60*j; search($sformatf("R5 lin j=%0d", j), 1'b0);
         lim = 1019 - 60*j; search($sformatf("R6 lin j=%0d m", j), 1'b0);
      end

      // R4 full polynomial, varied sensors and coefficients
      for (int s = 0; s < 10; s++) begin
         dmul = s % 3 + 1; doff = s; nmul = s % 2 + 1; noff = s*5; tmul = s % 4; toff = s*7;
         for (int k = 0; k < NT; k++) cf[k] = ((s*7919 + k*131 + s*k*17) % 2001) - 1000;
         cf[4] = -(4000 + s*300);
         grd = s*37 - 100;
         lim = pred_f((s + 3) % 16) + grd;
         search($sformatf("R4 poly s=%0d", s), 1'b0);
      end

      // R4 no wrap at extreme values; R2 start during search; R7 fail at max
      dmul = 0; doff = 31; nmul = 0; noff = 15; tmul = 0; toff = 15;
      for (int k = 0; k < NT; k++) cf[k] = 32767;
      grd = 0; lim = -1;
      search("R2 R4 R7 max pos", 1'b1);
      for (int k = 0; k < NT; k++) cf[k] = -32768;
      lim = -(longint'(32768) * 29791 * 2);
      search("R4 max neg", 1'b0);

      // R1 reset in mid-search
      for (int k = 0; k < NT; k++) cf[k] = 0;
      cf[0] = 5; lim = 0; grd = 0; load();
      @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
      repeat (60) @(negedge clk);
      rst = 1'b1; @(negedge clk); rst = 1'b0; @(negedge clk);
      check("R1 mid reset code", longint'(bias_code), 0);
      check("R1 mid reset flags", longint'({done, pass, det_req, node_req, temp_req}), 0);
      repeat (5) @(negedge clk);
      lim = 5; search("R1 after reset", 1'b0);

      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end
endmodule